// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the host-facing register side of a two-channel serial communications controller. A byte-wide register bus reaches each channel through two ports, a command port and a data port. The command port works through a register pointer: the first write picks a register and the next access writes or reads it. The pointer then falls back to register 0. Channel A also holds the master interrupt enable, the receive interrupt mode and a shared interrupt-pending byte. Reading that byte clears it, and so does any data-port read.

A byte written to a data port is passed out on a one-cycle transmit strobe. If local loopback is enabled for that channel, the byte is also queued into the channel's own receive FIFO. External receive bytes enter the same FIFO through a per-channel valid/data input. The bus accepts two other address forms on the same ports: a two-port layout at byte offsets 0x0F and 0x1F, and 16-bit accesses whose data byte sits in the upper half.

Top module: `dual_sio_regif`

## Requirements
- R1: `bus_addr[3]` selects the channel (0 = A, 1 = B) and `bus_addr[2:0]` selects the port: 1 is the command port and 5 is the data port. A read of any other offset returns 0, and a write to one changes no state. Read data appears on `bus_rdata` at the clock edge that ends the read cycle and holds until the next read.
- R2: A command-port write to a channel whose pointer is idle loads the pointer from bits 3:0 of the byte. The next command-port write stores the byte into the selected write register and returns the pointer to idle and register 0.
- R3: A command-port read returns the read register named by the pointer and then sets the pointer to idle and register 0.
- R4: Read register 0 has bit 2 set at all times and bit 0 set while that channel's receive FIFO holds data; its other bits are 0. Read registers 1, 2 and 4 to 11 and 14 to 15 read 0.
- R5: Read registers 12 and 13 return the last values written to write registers 12 and 13 of the same channel.
- R6: A data-port write produces a one-cycle `tx_valid` pulse on the next edge, with the byte on `tx_data` and the channel on `tx_chan`. If bit 4 of that channel's write register 14 is set, the byte is also pushed into that channel's receive FIFO.
- R7: A data-port read pops the oldest byte of that channel's 16-entry receive FIFO, or returns 0 if the FIFO is empty. A push into a full FIFO is dropped. An `rx_valid` bit pushes that channel's `rx_data` byte, unless a loopback push to the same channel happens in that cycle; then the loopback byte wins.
- R8: The pending byte has bit 5 = RX A, bit 4 = TX A, bit 2 = RX B and bit 1 = TX B; its other bits are 0. Reading register 3 through channel A's command port returns this byte and clears it. Register 3 read through channel B returns 0 and clears nothing.
- R9: While bit 3 of channel A's write register 9 is set and bits 4:3 of channel A's write register 1 are not 00, a channel whose receive FIFO holds data sets its RX pending bit on the next edge.
- R10: A data-port write sets that channel's TX pending bit if bit 3 of channel A's write register 9 and bit 1 of that channel's own write register 1 are both set.
- R11: `irq` is high while bit 3 of channel A's write register 9 is set and any pending bit is set. A data-port read of either channel clears the whole pending byte, and this clear takes priority over a set in the same cycle.
- R12: Byte offset 0x0F reaches channel A's command port and 0x1F reaches channel A's data port.
- R13: An access with `bus_wide` high to offset 0 or 4 with `bus_wdata[7:0]` = 0 acts as an access to offset 1 or 5 using `bus_wdata[15:8]`. Its read data is returned in `bus_rdata[15:8]`.
- R14: While `rst_n` is low, and for two clock edges after it rises, all registers, pointers, FIFOs and pending bits are cleared, with `irq`, `tx_valid` and `bus_rdata` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 16-bit access form |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 16 | Write data; also the low-byte qualifier for wide accesses |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_chan | output | 1 | Channel of the transmitted byte |
| tx_data | output | 8 | Transmitted byte |
| rx_valid | input | 2 | Receive byte strobe per channel (bit 0 = A) |
| rx_data_a | input | 8 | Receive byte for channel A |
| rx_data_b | input | 8 | Receive byte for channel B |

## Verification
Read data, the transmit strobe, register writes, FIFO pushes and pops, and pending-bit clears all show up one clock edge after the access cycle. A receive pending bit shows up one edge after the FIFO turns non-empty, so `irq` rises two edges after an `rx_valid` byte. The bench drives each access on a falling edge and lets one rising edge pass. It then compares the outputs on the next falling edge against a model it updated for that same edge. Directed checks that follow several-cycle sequences add idle cycles so the pending logic has its extra edge to settle.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [2:0] OFS_CMD   = 3'd1;
  localparam logic [2:0] OFS_DAT   = 3'd5;
  localparam logic [3:0] REG_STAT  = 4'd0;
  localparam logic [3:0] REG_IRQ   = 4'd3;
  localparam logic [3:0] REG_CTL1  = 4'd1;
  localparam logic [3:0] REG_MIC   = 4'd9;
  localparam logic [3:0] REG_TCL   = 4'd12;
  localparam logic [3:0] REG_TCH   = 4'd13;
  localparam logic [3:0] REG_MISC  = 4'd14;
  localparam int         NCH       = 2;

  typedef enum logic [1:0] {PORT_NONE, PORT_CMD, PORT_DAT} port_e;
endpackage

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          not_empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, do_push, do_pop;

  assign full      = (cnt_q == CW'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;
  assign head      = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  // R7
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt_q));
  // R7
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !not_empty && !push) |=> (cnt_q == '0));
endmodule

// File: rtl/sio_ptr_ctl.sv
module sio_ptr_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic       cmd_rd,
  input  logic [3:0] nib,
  output logic [3:0] ptr,
  output logic       reg_we
);
  logic [3:0] ptr_q, ptr_d;
  logic       busy_q, busy_d;

  assign ptr    = ptr_q;
  assign reg_we = cmd_wr && busy_q;

  always_comb begin
    ptr_d  = ptr_q;
    busy_d = busy_q;
    if (cmd_rd) begin
      ptr_d  = '0;
      busy_d = 1'b0;
    end else if (cmd_wr) begin
      if (!busy_q) begin
        ptr_d  = nib;
        busy_d = 1'b1;
      end else begin
        ptr_d  = '0;
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      busy_q <= busy_d;
    end
  end

  // R3
  ptr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |=> (!busy_q && ptr_q == 4'd0));
  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy_q) |=> (busy_q && ptr_q == $past(nib)));
  // R2
  ptr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy_q) |=> (!busy_q && ptr_q == 4'd0));
endmodule

// File: rtl/dual_sio_regif.sv
module dual_sio_regif #(
  parameter int DW         = 8,
  parameter int AW         = 5,
  parameter int FIFO_DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic            bus_wide,
  input  logic [AW-1:0]   bus_addr,
  input  logic [2*DW-1:0] bus_wdata,
  output logic [2*DW-1:0] bus_rdata,
  output logic            irq,
  output logic            tx_valid,
  output logic            tx_chan,
  output logic [DW-1:0]   tx_data,
  input  logic [1:0]      rx_valid,
  input  logic [DW-1:0]   rx_data_a,
  input  logic [DW-1:0]   rx_data_b
);
  import sio_pkg::*;

  localparam int RW = 2 * DW;

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_s <= rs1_q;
    end
  end

  // address decode and folding
  logic          ch, fold;
  logic [2:0]    ofs;
  port_e         port;
  logic [DW-1:0] wbyte;

  always_comb begin
    if (bus_addr[3:0] == 4'hF) begin
      ch  = 1'b0;
      ofs = (bus_addr[AW-1:4] != '0) ? OFS_DAT : OFS_CMD;
    end else begin
      ch  = bus_addr[3];
      ofs = bus_addr[2:0];
    end
    fold = bus_wide && (ofs == 3'd0 || ofs == 3'd4) && (bus_wdata[DW-1:0] == '0);
    if (fold) ofs = ofs + 3'd1;
    wbyte = fold ? bus_wdata[RW-1:DW] : bus_wdata[DW-1:0];
    case (ofs)
      OFS_CMD: port = PORT_CMD;
      OFS_DAT: port = PORT_DAT;
      default: port = PORT_NONE;
    endcase
  end

  logic is_rd, dat_wr, dat_rd;
  assign is_rd  = bus_sel && !bus_wr;
  assign dat_wr = bus_sel &&  bus_wr && port == PORT_DAT;
  assign dat_rd = is_rd && port == PORT_DAT;

  // per-channel state
  logic [NCH-1:0][3:0]    ptr;
  logic [NCH-1:0]         reg_we, txie_q, lb_q, ne;
  logic [NCH-1:0][DW-1:0] tcl_q, tch_q, head;
  logic [NCH-1:0][DW-1:0] rx_bytes;
  logic                   mie_q;
  logic [1:0]             rxm_q;

  assign rx_bytes = {rx_data_b, rx_data_a};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          sel_g, lb_push;
    assign sel_g   = (ch == 1'(g));
    assign lb_push = dat_wr && sel_g && lb_q[g];

    sio_ptr_ctl u_ptr (
      .clk    (clk),
      .rst_n  (rst_s),
      .cmd_wr (bus_sel && bus_wr && port == PORT_CMD && sel_g),
      .cmd_rd (is_rd && port == PORT_CMD && sel_g),
      .nib    (wbyte[3:0]),
      .ptr    (ptr[g]),
      .reg_we (reg_we[g])
    );

    sio_rx_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_s),
      .push      (lb_push || rx_valid[g]),
      .push_data (lb_push ? wbyte : rx_bytes[g]),
      .pop       (dat_rd && sel_g),
      .head      (head[g]),
      .not_empty (ne[g])
    );

    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) begin
        txie_q[g] <= 1'b0;
        lb_q[g]   <= 1'b0;
        tcl_q[g]  <= '0;
        tch_q[g]  <= '0;
      end else if (reg_we[g]) begin
        if (ptr[g] == REG_CTL1) txie_q[g] <= wbyte[1];
        if (ptr[g] == REG_MISC) lb_q[g]   <= wbyte[4];
        if (ptr[g] == REG_TCL)  tcl_q[g]  <= wbyte;
        if (ptr[g] == REG_TCH)  tch_q[g]  <= wbyte;
      end
    end
  end

  // channel-A-only controls
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mie_q <= 1'b0;
      rxm_q <= 2'b00;
    end else if (reg_we[0]) begin
      if (ptr[0] == REG_MIC)  mie_q <= wbyte[3];
      if (ptr[0] == REG_CTL1) rxm_q <= wbyte[4:3];
    end
  end

  // pending: [3]=rx A, [2]=tx A, [1]=rx B, [0]=tx B
  logic [3:0]    pend_q, pend_d;
  logic [DW-1:0] pend_byte, rd_byte;
  logic          rr3_clr;

  assign pend_byte = DW'({2'b00, pend_q[3], pend_q[2], 1'b0, pend_q[1], pend_q[0], 1'b0});
  assign rr3_clr   = is_rd && port == PORT_CMD && !ch && ptr[0] == REG_IRQ;

  always_comb begin
    pend_d = pend_q;
    if (mie_q && rxm_q != 2'b00) begin
      if (ne[0]) pend_d[3] = 1'b1;
      if (ne[1]) pend_d[1] = 1'b1;
    end
    if (dat_wr && mie_q && txie_q[ch]) begin
      if (!ch) pend_d[2] = 1'b1;
      else     pend_d[0] = 1'b1;
    end
    if (dat_rd || rr3_clr) pend_d = '0;
  end

  always_comb begin
    rd_byte = '0;
    if (port == PORT_CMD) begin
      case (ptr[ch])
        REG_STAT: rd_byte = DW'({5'b00000, 1'b1, 1'b0, ne[ch]});
        REG_IRQ:  rd_byte = ch ? '0 : pend_byte;
        REG_TCL:  rd_byte = tcl_q[ch];
        REG_TCH:  rd_byte = tch_q[ch];
        default:  rd_byte = '0;
      endcase
    end else if (port == PORT_DAT) begin
      rd_byte = ne[ch] ? head[ch] : '0;
    end
  end

  logic [RW-1:0] rdata_q, rdata_d;
  logic          txv_q, txc_q;
  logic [DW-1:0] txd_q;

  assign rdata_d = fold ? {rd_byte, {DW{1'b0}}} : {{DW{1'b0}}, rd_byte};

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pend_q  <= '0;
      rdata_q <= '0;
      txv_q   <= 1'b0;
      txc_q   <= 1'b0;
      txd_q   <= '0;
    end else begin
      pend_q <= pend_d;
      txv_q  <= dat_wr;
      if (is_rd)  rdata_q <= rdata_d;
      if (dat_wr) begin
        txc_q <= ch;
        txd_q <= wbyte;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign tx_valid  = txv_q;
  assign tx_chan   = txc_q;
  assign tx_data   = txd_q;
  assign irq       = mie_q && (pend_q != '0);

  // R11
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_s)
    dat_rd |=> (pend_q == 4'd0 && !irq));
  // R6
  tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_s)
    dat_wr |=> (tx_valid && tx_data == $past(wbyte) && tx_chan == $past(ch)));
  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !is_rd |=> $stable(bus_rdata));
  // R10
  tx_pend_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (dat_wr && mie_q && txie_q[ch] && !dat_rd) |=> irq);
endmodule

// File: tb/dual_sio_regif_test.sv
`timescale 1ns/1ps
module dual_sio_regif_test;
  localparam real CLK_NS = 20.0;

  logic        clk, rst_n;
  logic        bus_sel, bus_wr, bus_wide;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        irq, tx_valid, tx_chan;
  logic [7:0]  tx_data, rx_data_a, rx_data_b;
  logic [1:0]  rx_valid;

  dual_sio_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .tx_valid(tx_valid), .tx_chan(tx_chan),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data_a(rx_data_a),
    .rx_data_b(rx_data_b)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2.0) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic       m_busy [2];
  logic [3:0] m_ptr  [2];
  logic       m_txie [2];
  logic       m_lb   [2];
  logic [7:0] m_tcl  [2];
  logic [7:0] m_tch  [2];
  logic       m_mie;
  logic [1:0] m_rxm;
  logic [7:0] m_pend;
  logic [15:0] m_rdata;
  logic [7:0] fq0[$];
  logic [7:0] fq1[$];
  logic [15:0] last;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_busy[i] = 0; m_ptr[i] = 0; m_txie[i] = 0; m_lb[i] = 0;
      m_tcl[i] = 0; m_tch[i] = 0;
    end
    m_mie = 0; m_rxm = 0; m_pend = 0; m_rdata = 0;
    fq0.delete(); fq1.delete();
  endtask

  function automatic int qsize(input int c);
    return (c == 0) ? fq0.size() : fq1.size();
  endfunction

  // one bus cycle: drive at falling edge, model the rising edge, compare at next falling edge
  task automatic cyc(input logic s, input logic w, input logic wide, input logic [4:0] a,
                     input logic [15:0] d, input logic [1:0] rv, input logic [7:0] ra,
                     input logic [7:0] rb, input string tag);
    int c; logic [2:0] o; logic f; logic [7:0] b, rd; logic [7:0] pn;
    logic exp_txv; logic [7:0] exp_txd; logic rxen, pushed;
    logic [7:0] pb;
    bus_sel = s; bus_wr = w; bus_wide = wide; bus_addr = a; bus_wdata = d;
    rx_valid = rv; rx_data_a = ra; rx_data_b = rb;
    if (a[3:0] == 4'hF) begin c = 0; o = a[4] ? 3'd5 : 3'd1; end
    else begin c = int'(a[3]); o = a[2:0]; end
    f = wide && (o == 3'd0 || o == 3'd4) && d[7:0] == 8'h00;
    if (f) o = o + 3'd1;
    b = f ? d[15:8] : d[7:0];
    rd = 8'h00;
    if (s && !w) begin
      if (o == 3'd1) begin
        case (m_ptr[c])
          4'd0: rd = 8'h04 | ((qsize(c) > 0) ? 8'h01 : 8'h00);
          4'd3: rd = (c == 0) ? m_pend : 8'h00;
          4'd12: rd = m_tcl[c];
          4'd13: rd = m_tch[c];
          default: rd = 8'h00;
        endcase
      end else if (o == 3'd5 && qsize(c) > 0) begin
        rd = (c == 0) ? fq0[0] : fq1[0];
      end
      m_rdata = f ? {rd, 8'h00} : {8'h00, rd};
    end
    pn = m_pend;
    rxen = m_mie && (m_rxm != 2'b00);
    if (rxen && fq0.size() > 0) pn[5] = 1;
    if (rxen && fq1.size() > 0) pn[2] = 1;
    exp_txv = s && w && o == 3'd5;
    exp_txd = b;
    if (exp_txv && m_mie && m_txie[c]) begin
      if (c == 0) pn[4] = 1; else pn[1] = 1;
    end
    if ((s && !w && o == 3'd5) || (s && !w && o == 3'd1 && c == 0 && m_ptr[0] == 4'd3)) pn = 0;
    // FIFOs
    for (int k = 0; k < 2; k++) begin
      logic full; full = (qsize(k) == 16);
      if (s && !w && o == 3'd5 && c == k && qsize(k) > 0) begin
        if (k == 0) void'(fq0.pop_front()); else void'(fq1.pop_front());
      end
      pushed = 0;
      if (exp_txv && c == k && m_lb[k]) begin pushed = 1; pb = b; end
      else if (rv[k]) begin pushed = 1; pb = (k == 0) ? ra : rb; end
      if (pushed && !full) begin
        if (k == 0) fq0.push_back(pb); else fq1.push_back(pb);
      end
    end
    // pointer and registers
    if (s && o == 3'd1) begin
      if (!w) begin m_ptr[c] = 0; m_busy[c] = 0; end
      else if (!m_busy[c]) begin m_ptr[c] = b[3:0]; m_busy[c] = 1; end
      else begin
        case (m_ptr[c])
          4'd1: begin m_txie[c] = b[1]; if (c == 0) m_rxm = b[4:3]; end
          4'd9: if (c == 0) m_mie = b[3];
          4'd12: m_tcl[c] = b;
          4'd13: m_tch[c] = b;
          4'd14: m_lb[c] = b[4];
          default: ;
        endcase
        m_ptr[c] = 0; m_busy[c] = 0;
      end
    end
    m_pend = pn;
    @(posedge clk);
    @(negedge clk);
    chk("R6 tx_valid", {15'd0, tx_valid}, {15'd0, exp_txv});
    if (exp_txv) begin
      chk("R6 tx_data", {8'd0, tx_data}, {8'd0, exp_txd});
      chk("R6 tx_chan", {15'd0, tx_chan}, c[15:0]);
    end
    chk("R11 irq", {15'd0, irq}, {15'd0, m_mie && (m_pend != 0)});
    chk(tag, bus_rdata, m_rdata);
    last = bus_rdata;
    bus_sel = 0; bus_wr = 0; bus_wide = 0; rx_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 5'd0, 16'h0, 2'b00, 8'h0, 8'h0, "R1 idle");
  endtask

  task automatic wreg(input logic [4:0] ca, input logic [3:0] idx, input logic [7:0] v);
    cyc(1, 1, 0, ca, {12'h0, idx}, 2'b00, 8'h0, 8'h0, "R2 ptr");
    cyc(1, 1, 0, ca, {8'h0, v}, 2'b00, 8'h0, 8'h0, "R2 wr");
  endtask

  task automatic rreg(input logic [4:0] ca, input logic [3:0] idx);
    if (idx != 0) cyc(1, 1, 0, ca, {12'h0, idx}, 2'b00, 8'h0, 8'h0, "R2 ptr");
    cyc(1, 0, 0, ca, 16'h0, 2'b00, 8'h0, 8'h0, "R3 cmd read");
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_fail++;
    $display("FAIL R14 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    bus_sel = 0; bus_wr = 0; bus_wide = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_data_a = 0; rx_data_b = 0;
    model_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R14: reset values
    chk("R14 irq", {15'd0, irq}, 16'h0);
    chk("R14 tx_valid", {15'd0, tx_valid}, 16'h0);
    chk("R14 rdata", bus_rdata, 16'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    rreg(5'd1, 4'd0);
    chk("R4 RR0 empty", last, 16'h0004);
    rreg(5'd9, 4'd1);
    chk("R4 RR1 zero", last, 16'h0000);

    // R5 mirror of time constant
    wreg(5'd1, 4'd12, 8'h5A);
    rreg(5'd1, 4'd12);
    chk("R5 RR12 A", last, 16'h005A);
    wreg(5'd9, 4'd13, 8'hC3);
    rreg(5'd9, 4'd13);
    chk("R5 RR13 B", last, 16'h00C3);
    // R3: pointer back to 0 after a read
    cyc(1, 1, 0, 5'd1, 16'h000C, 2'b00, 8'h0, 8'h0, "R2 ptr");
    cyc(1, 0, 0, 5'd1, 16'h0, 2'b00, 8'h0, 8'h0, "R3 read");
    rreg(5'd1, 4'd0);
    chk("R3 ptr reset", last, 16'h0004);

    // R6/R7 loopback on A
    wreg(5'd1, 4'd14, 8'h10);
    cyc(1, 1, 0, 5'd5, 16'h0041, 2'b00, 8'h0, 8'h0, "R6 data wr");
    chk("R6 strobe", {7'd0, tx_chan, tx_data}, 16'h0041);
    rreg(5'd1, 4'd0);
    chk("R4 RR0 avail", last, 16'h0005);
    cyc(1, 0, 0, 5'd5, 16'h0, 2'b00, 8'h0, 8'h0, "R7 pop");
    chk("R7 pop byte", last, 16'h0041);
    cyc(1, 0, 0, 5'd5, 16'h0, 2'b00, 8'h0, 8'h0, "R7 pop empty");
    chk("R7 empty zero", last, 16'h0000);

    // R7 full FIFO drops on B
    wreg(5'd9, 4'd14, 8'h10);
    for (int i = 0; i < 18; i++) cyc(1, 1, 0, 5'd13, 16'(i + 8'h30), 2'b00, 8'h0, 8'h0, "R6 wr B");
    for (int i = 0; i < 17; i++) begin
      cyc(1, 0, 0, 5'd13, 16'h0, 2'b00, 8'h0, 8'h0, "R7 drain B");
      chk("R7 fifo order", last, (i < 16) ? 16'(i + 8'h30) : 16'h0000);
    end
    wreg(5'd9, 4'd14, 8'h00);

    // R9 / R8 receive interrupt
    wreg(5'd1, 4'd9, 8'h08);
    wreg(5'd1, 4'd1, 8'h08);
    cyc(0, 0, 0, 5'd0, 16'h0, 2'b01, 8'h77, 8'h0, "R7 rx push");
    chk("R9 not yet", {15'd0, irq}, 16'h0);
    idle(1);
    chk("R9 irq up", {15'd0, irq}, 16'h0001);
    rreg(5'd1, 4'd3);
    chk("R8 pending RX A", last, 16'h0020);
    rreg(5'd9, 4'd3);
    chk("R8 B reg3 zero", last, 16'h0000);
    cyc(1, 0, 0, 5'd5, 16'h0, 2'b00, 8'h0, 8'h0, "R7 pop");
    chk("R11 cleared by data read", {15'd0, irq}, 16'h0);
    idle(2);
    chk("R11 stays low", {15'd0, irq}, 16'h0);

    // R10 transmit pending
    wreg(5'd1, 4'd1, 8'h02);
    cyc(1, 1, 0, 5'd5, 16'h0022, 2'b00, 8'h0, 8'h0, "R10 data wr");
    chk("R10 irq", {15'd0, irq}, 16'h0001);
    rreg(5'd1, 4'd3);
    chk("R10 pending TX A", last, 16'h0010);
    cyc(1, 0, 0, 5'd5, 16'h0, 2'b00, 8'h0, 8'h0, "R7 pop");
    wreg(5'd1, 4'd1, 8'h00);
    wreg(5'd1, 4'd9, 8'h00);

    // R12 alternate layout
    wreg(5'h0F, 4'd12, 8'h99);
    rreg(5'd1, 4'd12);
    chk("R12 cmd via 0x0F", last, 16'h0099);
    cyc(1, 1, 0, 5'h1F, 16'h0066, 2'b00, 8'h0, 8'h0, "R12 data via 0x1F");
    cyc(1, 0, 0, 5'h1F, 16'h0, 2'b00, 8'h0, 8'h0, "R12 read 0x1F");
    chk("R12 loopback via 0x1F", last, 16'h0066);

    // R13 wide fold
    cyc(1, 1, 1, 5'd0, 16'h0D00, 2'b00, 8'h0, 8'h0, "R13 ptr");
    cyc(1, 1, 1, 5'd0, 16'h3300, 2'b00, 8'h0, 8'h0, "R13 wr");
    cyc(1, 1, 1, 5'd0, 16'h0D00, 2'b00, 8'h0, 8'h0, "R13 ptr");
    cyc(1, 0, 1, 5'd0, 16'h0000, 2'b00, 8'h0, 8'h0, "R13 read");
    chk("R13 wide read", last, 16'h3300);

    // R1 other offsets
    cyc(1, 1, 0, 5'd2, 16'h000C, 2'b00, 8'h0, 8'h0, "R1 ignored wr");
    cyc(1, 0, 0, 5'd2, 16'h0, 2'b00, 8'h0, 8'h0, "R1 other read");
    chk("R1 other offset zero", last, 16'h0000);
    rreg(5'd1, 4'd0);
    chk("R1 pointer untouched", last[7:4], 16'h0000);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a; logic [15:0] d; logic wide; int r;
      r = $urandom % 10;
      case (r)
        0: a = 5'd1;  1: a = 5'd5;  2: a = 5'd9;  3: a = 5'd13;
        4: a = 5'h0F; 5: a = 5'h1F; 6: a = 5'd0;  7: a = 5'd4;
        8: a = 5'd12; default: a = 5'd2;
      endcase
      wide = ($urandom % 3) == 0;
      d = 16'($urandom);
      if (wide && ($urandom % 2)) d[7:0] = 8'h00;
      cyc(($urandom % 4) != 0, $urandom % 2, wide, a, d, 2'($urandom % 4 == 0 ? $urandom : 0),
          8'($urandom), 8'($urandom), "R1 random rdata");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule